// File: doc/BRIEF.md
# Dual-Address DMA Channel

This block is one DMA channel that copies data between two addresses on a shared memory bus. Each transfer unit is two bus cycles: a read from the source address, then a write of the captured word to the destination address. Software programs a source address, a destination address, a byte count and a mode word through a small register port. It then sets the enable bit in the control register. The channel runs until the count is used up, raises a done flag and, if allowed, an interrupt.

Each side has its own transfer size and its own address behaviour: the address either advances after every access or stays fixed. In cycle-steal mode the channel waits for a rising edge on an external request line before each unit, instead of running the whole count without a break.

Top module: `dma_dual_chan`

## Requirements
- R1: Every unit is a source read followed by a destination write. The full word captured on `bus_rdata` when the read is accepted appears on `bus_wdata` during the write that follows.
- R2: Size codes are 0 = 32-bit, 1 = 8-bit, 2 = 16-bit, 3 = line. `bus_size` carries the code of the side being accessed, and a line side is presented as code 0.
- R3: An incrementing address advances after each accepted access on its side, by 4, 1, 2 or 4 bytes for size codes 0, 1, 2 and 3. A fixed address never changes during a transfer.
- R4: A line source makes one unit of 16 bytes, carried out as four read/write beat pairs.
- R5: The count register (select 2) keeps only the low 24 bits of a write. After each unit it drops by the source unit's byte size, and it saturates at zero. The transfer ends when it reaches zero, and the count then reads 0.
- R6: Writing the control register (select 4) with bit 0 set starts an idle channel with a nonzero count. If the count is zero, no transfer starts and the configuration-error status bit 5 is set instead.
- R7: A control write with bit 0 clear and bit 1 set aborts any transfer at once, drops the bus request and clears status bit 5.
- R8: Status bit 3 (done) sets at the end of a transfer. A control write with bit 3 set clears it. Every control write loads the interrupt enable from bit 2. `irq` is high exactly while done and the interrupt enable are both set, one cycle later.
- R9: With mode bit 8 set, each rising edge of `dreq` moves exactly one unit. A level held high counts as one edge.
- R10: While `bus_req` is high and `bus_ready` is low, the address, direction, size and write data hold steady.
- R11: Writes to the source (select 0), destination (select 1), count and mode (select 3) registers are ignored while the channel is busy (status bit 0). Reads return live values one cycle after `reg_sel`.
- R12: Mode word fields are: bit 0 source fixed, bits 2:1 source size, bit 4 destination fixed, bits 6:5 destination size, bit 8 cycle steal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 src, 1 dst, 2 count, 3 mode, 4 control/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_sel` |
| dreq | input | 1 | External request for cycle-steal mode |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Byte address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Access accepted at this edge |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest condition to reach is a busy channel that is not moving, where register writes must be dropped. Cycle-steal mode is used to park the channel between requests. Overwriting the source address there, then reading it back, shows the live post-increment value. A sweep over all source/destination size and address-mode combinations uses a responder with changing wait states, so every access is also checked for hold-until-ready. Counts are chosen so that byte totals that are not a multiple of the unit size hit the saturating last unit.

// File: rtl/dma_dual_pkg.sv
package dma_dual_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_LINE = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_WRITE
  } chan_state_e;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_MODE = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;

  localparam int LINE_BEATS = 4;

  // bytes retired from the count per unit
  function automatic logic [4:0] unit_bytes(xfer_size_e s);
    case (s)
      SZ_BYTE: return 5'd1;
      SZ_HALF: return 5'd2;
      SZ_LINE: return 5'd16;
      default: return 5'd4;
    endcase
  endfunction

  // address advance per single bus access
  function automatic logic [2:0] access_bytes(xfer_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_dual_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          fixed,
  input  xfer_size_e    size,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (step && !fixed) begin
      addr <= addr + AW'(access_bytes(size));
    end
  end

  // R3
  fixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fixed && !load) |=> $stable(addr));

endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int CW    = 24,
  parameter int AMT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CW-1:0]    load_val,
  input  logic             dec,
  input  logic [AMT_W-1:0] amt,
  output logic [CW-1:0]    count,
  output logic             last
);

  assign last = (count <= CW'(amt));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec) begin
      count <= last ? '0 : count - CW'(amt);
    end
  end

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count <= $past(count)));

endmodule

// File: rtl/dma_dual_chan.sv
module dma_dual_chan
  import dma_dual_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          dreq,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          irq
);

  localparam int MODE_W = 9;
  localparam int BEAT_W = $clog2(LINE_BEATS);

  chan_state_e       state_q, state_d;
  logic [BEAT_W-1:0] beat_q;
  logic [DW-1:0]     data_q;
  logic [MODE_W-1:0] mode_q;
  logic done_q, ien_q, err_q, dreq_q, irq_q;

  logic [CW-1:0] count;
  logic          cnt_last;

  logic          side_load  [2];
  logic          side_step  [2];
  logic          side_fixed [2];
  xfer_size_e    side_size  [2];
  logic [AW-1:0] side_addr  [2];

  xfer_size_e src_size, dst_size;
  logic busy, ctrl_wr, stop, start, start_bad;
  logic rd_ack, wr_ack, last_beat, unit_end, steal, steal_go;

  assign src_size = xfer_size_e'(mode_q[2:1]);
  assign dst_size = xfer_size_e'(mode_q[6:5]);
  assign steal    = mode_q[8];

  assign busy      = (state_q != ST_IDLE);
  assign ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL);
  assign stop      = ctrl_wr && !reg_wdata[0] && reg_wdata[1];
  assign start     = ctrl_wr && reg_wdata[0] && !busy && (count != '0);
  assign start_bad = ctrl_wr && reg_wdata[0] && !busy && (count == '0);
  assign rd_ack    = (state_q == ST_READ) && bus_ready;
  assign wr_ack    = (state_q == ST_WRITE) && bus_ready;
  assign last_beat = (src_size != SZ_LINE) || (beat_q == BEAT_W'(LINE_BEATS - 1));
  assign unit_end  = wr_ack && last_beat;
  assign steal_go  = dreq && !dreq_q;

  // source side index 0, destination side index 1
  assign side_load[0]  = reg_wr && (reg_sel == SEL_SRC) && !busy;
  assign side_load[1]  = reg_wr && (reg_sel == SEL_DST) && !busy;
  assign side_step[0]  = rd_ack;
  assign side_step[1]  = wr_ack;
  assign side_fixed[0] = mode_q[0];
  assign side_fixed[1] = mode_q[4];
  assign side_size[0]  = src_size;
  assign side_size[1]  = dst_size;

  for (genvar g = 0; g < 2; g++) begin : g_side
    dma_addr_step #(.AW(AW)) u_step (
      .clk      (clk),
      .rst      (rst),
      .load     (side_load[g]),
      .load_val (reg_wdata[AW-1:0]),
      .step     (side_step[g]),
      .fixed    (side_fixed[g]),
      .size     (side_size[g]),
      .addr     (side_addr[g])
    );
  end

  dma_byte_counter #(.CW(CW), .AMT_W(5)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (reg_wr && (reg_sel == SEL_CNT) && !busy),
    .load_val (reg_wdata[CW-1:0]),
    .dec      (unit_end),
    .amt      (unit_bytes(src_size)),
    .count    (count),
    .last     (cnt_last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = steal ? ST_WAIT : ST_READ;
      ST_WAIT:  if (steal_go) state_d = ST_READ;
      ST_READ:  if (rd_ack) state_d = ST_WRITE;
      ST_WRITE: if (wr_ack) begin
        if (!last_beat)    state_d = ST_READ;
        else if (cnt_last) state_d = ST_IDLE;
        else               state_d = steal ? ST_WAIT : ST_READ;
      end
      default:  state_d = ST_IDLE;
    endcase
    if (stop) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      data_q  <= '0;
      mode_q  <= '0;
      done_q  <= 1'b0;
      ien_q   <= 1'b0;
      err_q   <= 1'b0;
      dreq_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dreq_q  <= dreq;
      irq_q   <= done_q && ien_q;
      if (rd_ack) data_q <= bus_rdata;
      if (start || unit_end) beat_q <= '0;
      else if (wr_ack)       beat_q <= beat_q + 1'b1;
      if (reg_wr && (reg_sel == SEL_MODE) && !busy) mode_q <= reg_wdata[MODE_W-1:0];
      if (ctrl_wr) ien_q <= reg_wdata[2];
      if (start_bad) err_q <= 1'b1;
      else if (stop) err_q <= 1'b0;
      if (unit_end && cnt_last)          done_q <= 1'b1;
      else if (start)                    done_q <= 1'b0;
      else if (ctrl_wr && reg_wdata[3])  done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_sel)
        SEL_SRC:  reg_rdata <= 32'(side_addr[0]);
        SEL_DST:  reg_rdata <= 32'(side_addr[1]);
        SEL_CNT:  reg_rdata <= 32'(count);
        SEL_MODE: reg_rdata <= 32'(mode_q);
        SEL_CTRL: reg_rdata <= {26'd0, err_q, 1'b0, done_q, ien_q, 1'b0, busy};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign bus_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_we    = (state_q == ST_WRITE);
  assign bus_addr  = bus_we ? side_addr[1] : side_addr[0];
  assign bus_size  = bus_we ? ((dst_size == SZ_LINE) ? SZ_LONG : dst_size)
                            : ((src_size == SZ_LINE) ? SZ_LONG : src_size);
  assign bus_wdata = data_q;
  assign irq       = irq_q;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready && !stop) |=> (bus_req && $stable(bus_addr) &&
      $stable(bus_we) && $stable(bus_size) && $stable(bus_wdata)));

  // R1
  read_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_we) |-> $past(bus_req && !bus_we && bus_ready));

  // R5
  done_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (count == '0));

  // R6
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctrl_wr && reg_wdata[0]));

endmodule

// File: tb/dma_dual_chan_test.sv
module dma_dual_chan_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        dreq;
  logic        bus_req, bus_we, bus_ready, irq;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  bit          model_on = 0;
  int          ss, ds;
  bit          sfix, dfix;
  logic [31:0] exp_src, exp_dst, last_rd;
  int          nrd, nwr, acc, wcnt;
  bit          stall_seen;
  logic [31:0] stall_addr;
  logic        stall_we;

  always #10 clk = ~clk;

  dma_dual_chan uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, a[15:0]};
  endfunction

  function automatic int stepb(input int s);
    return (s == 1) ? 1 : (s == 2) ? 2 : 4;
  endfunction

  function automatic int unitb(input int s);
    return (s == 1) ? 1 : (s == 2) ? 2 : (s == 3) ? 16 : 4;
  endfunction

  // memory responder with varying wait states
  initial begin
    bus_ready = 1'b0; bus_rdata = '0; wcnt = 0; acc = 0; stall_seen = 0;
    forever begin
      @(negedge clk);
      bus_ready = 1'b0;
      if (stall_seen && bus_req)
        chk(bus_addr == stall_addr && bus_we == stall_we, "R10 hold", bus_addr, stall_addr);
      stall_seen = 0;
      bus_rdata = pat(bus_addr);
      if (bus_req && !rst) begin
        if (wcnt >= acc % 3) begin
          bus_ready = 1'b1;
          wcnt = 0;
          acc++;
          if (model_on) begin
            if (!bus_we) begin
              chk(bus_addr == exp_src, "R3 src addr", bus_addr, exp_src);
              chk(bus_size == 2'((ss == 3) ? 0 : ss), "R2 src size", 32'(bus_size), 32'(ss));
              last_rd = pat(bus_addr);
              if (!sfix) exp_src = exp_src + 32'(stepb(ss));
              nrd++;
            end else begin
              chk(bus_addr == exp_dst, "R3 dst addr", bus_addr, exp_dst);
              chk(bus_size == 2'((ds == 3) ? 0 : ds), "R2 dst size", 32'(bus_size), 32'(ds));
              chk(bus_wdata == last_rd, "R1 write data", bus_wdata, last_rd);
              if (!dfix) exp_dst = exp_dst + 32'(stepb(ds));
              nwr++;
            end
          end
        end else begin
          wcnt++;
          stall_seen = 1;
          stall_addr = bus_addr;
          stall_we = bus_we;
        end
      end
    end
  end

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [31:0] val);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    val = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(3'd4, st);
      if (!st[0]) break;
    end
  endtask

  task automatic setup(input int s, input int d, input bit sf, input bit df,
                       input logic [31:0] n, input bit stl);
    ss = s; ds = d; sfix = sf; dfix = df;
    exp_src = 32'h0000_1000 + 32'(s * 64);
    exp_dst = 32'h0004_0000 + 32'(d * 64);
    nrd = 0; nwr = 0;
    wr_reg(3'd0, exp_src);
    wr_reg(3'd1, exp_dst);
    wr_reg(3'd2, n);
    wr_reg(3'd3, {23'd0, stl, 1'b0, 2'(d), df, 1'b0, 2'(s), sf});
    model_on = 1;
  endtask

  task automatic run_cfg(input int s, input int d, input bit sf, input bit df, input int n);
    logic [31:0] v;
    int units, beats;
    setup(s, d, sf, df, 32'(n), 1'b0);
    wr_reg(3'd4, 32'h5);
    wait_idle();
    units = (n + unitb(s) - 1) / unitb(s);
    beats = (s == 3) ? 4 : 1;
    chk(nrd == units * beats, "R4 read count", 32'(nrd), 32'(units * beats));
    chk(nwr == nrd, "R1 pairing", 32'(nwr), 32'(nrd));
    rd_reg(3'd2, v);
    chk(v == 0, "R5 count zero", v, 0);
    rd_reg(3'd4, v);
    chk(v[3] == 1'b1, "R8 done set", v, 32'h8);
    chk(irq == 1'b1, "R8 irq high", 32'(irq), 1);
    wr_reg(3'd4, 32'hC);
    rd_reg(3'd4, v);
    chk(v[3] == 1'b0 && irq == 1'b0, "R8 done cleared", {v[31:1], irq}, 0);
  endtask

  task automatic pulse(input int len);
    @(negedge clk); dreq = 1'b1;
    repeat (len) @(negedge clk);
    dreq = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; reg_wr = 0; reg_sel = 0; reg_wdata = 0; dreq = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !irq, "R6 reset idle", {bus_req, irq}, 0);
    rd_reg(3'd4, v);
    chk(v == 0, "R8 reset status", v, 0);

    // R5 count keeps low 24 bits
    wr_reg(3'd2, 32'hFF00_0005);
    rd_reg(3'd2, v);
    chk(v == 32'h5, "R5 count mask", v, 5);

    // R12 mode readback
    wr_reg(3'd3, 32'h0000_0177);
    rd_reg(3'd3, v);
    chk(v == 32'h177, "R12 mode field", v, 32'h177);

    // sweep every size and address-mode pairing
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        for (int f = 0; f < 4; f++)
          run_cfg(s, d, f[0], f[1], 1 + (((s * 16 + d * 4 + f) * 7) % 37));

    // R6 start with zero count
    wr_reg(3'd4, 32'h1);
    rd_reg(3'd4, v);
    chk(v[5] == 1'b1 && v[0] == 1'b0, "R6 config error", v, 32'h20);
    wr_reg(3'd4, 32'h2);
    rd_reg(3'd4, v);
    chk(v[5] == 1'b0, "R7 error cleared", v, 0);

    // R8 interrupt disabled
    setup(1, 1, 0, 0, 32'd3, 1'b0);
    wr_reg(3'd4, 32'h1);
    wait_idle();
    rd_reg(3'd4, v);
    chk(v[3] == 1'b1 && irq == 1'b0, "R8 irq masked", {v[31:1], irq}, 32'h8);
    wr_reg(3'd4, 32'h8);

    // R9 cycle steal, R11 writes ignored while busy
    setup(1, 1, 0, 0, 32'd3, 1'b1);
    wr_reg(3'd4, 32'h5);
    repeat (10) @(negedge clk);
    chk(nrd == 0, "R9 waits for request", 32'(nrd), 0);
    pulse(1);
    rd_reg(3'd2, v);
    chk(v == 2 && nrd == 1, "R9 one unit", v, 2);
    wr_reg(3'd0, 32'hDEAD_0000);
    wr_reg(3'd2, 32'h77);
    rd_reg(3'd0, v);
    chk(v == exp_src, "R11 src write ignored", v, exp_src);
    rd_reg(3'd2, v);
    chk(v == 2, "R11 count write ignored", v, 2);
    pulse(15);
    rd_reg(3'd2, v);
    chk(v == 1 && nrd == 2, "R9 held level one unit", v, 1);
    pulse(1);
    rd_reg(3'd4, v);
    chk(v[0] == 1'b0 && v[3] == 1'b1, "R9 finished", v, 32'hC);
    wr_reg(3'd4, 32'h8);

    // R7 abort a long transfer
    setup(0, 0, 1, 1, 32'h000F_FFFF, 1'b0);
    wr_reg(3'd4, 32'h1);
    repeat (30) @(negedge clk);
    wr_reg(3'd4, 32'h2);
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0, "R7 bus released", 32'(bus_req), 0);
    rd_reg(3'd4, v);
    chk(v[0] == 1'b0 && v[3] == 1'b0, "R7 stopped not done", v, 0);
    rd_reg(3'd2, v);
    chk(v != 0 && v < 32'h000F_FFFF, "R7 partial count", v, 32'h000F_FFFF);
    model_on = 0;

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule